// File: doc/BRIEF.md
# Two-Output Power-Up and Fault Sequencer

This block supervises start-up and shutdown of a converter controller with two regulated outputs: an auxiliary output that powers the controller, and a main output pair. It sees only digitized comparator flags: supply above turn-on, reference good, input undervoltage, input overvoltage, overcurrent, an enable pin with selectable polarity, two flags that compare the bootstrapped supply with the main supply, and one undervoltage flag per regulated output. From these it drives two run signals and a latched-off status.

Start-up is staged. The auxiliary run signal rises first. The main run signal follows only once the bootstrapped supply has overtaken the main supply. Faults fall into two classes. A plain fault drops both run signals, and the block restarts by itself once the fault has cleared and the bootstrapped supply has sagged below its restart level. A sustained output undervoltage, timed by a counter, latches the block off. Leaving that latch needs a deliberate toggle of enable or of the input-undervoltage flag.

Top module: `supply_sequencer`

## Requirements
- R1: With `en_pol_i`=1 the block is enabled when `en_i`=0. With `en_pol_i`=0 it is enabled when `en_i`=1. A floating enable pin is expected to be pulled to 1 outside the block.
- R2: From the off state, `run_aux_o` rises on the clock edge after supply-on, reference-good and enabled are true together and no input undervoltage, overvoltage or overcurrent flag is set.
- R3: `run_main_o` is only ever high while `run_aux_o` is high. It rises one edge after `boot_gt_main_i` is sampled high while the auxiliary output runs.
- R4: Any fault drops both run signals on the next edge. A fault is supply-on low, reference-good low, `in_uv_i`, `in_ov_i`, `ovc_i`, or the disabled state.
- R5: While a run signal is high, if `out_uv_a_i` or `out_uv_b_i` is high on TMR_LIMIT consecutive edges, the block latches off on the last of those edges. `latched_off_o`=1 and both run signals are 0.
- R6: The undervoltage timer clears to zero on any edge where both output undervoltage flags are low, so separate shorter episodes do not add up.
- R7: After a non-latched fault, the block stays off until the fault is gone and `boot_low_i` is high. It then raises `run_aux_o` on the next edge.
- R8: The block leaves the latched-off state only on an edge where `en_i` or `in_uv_i` differs from its value on the previous edge, `boot_low_i`=1, and both output undervoltage flags are low. It then goes to the off state.
- R9: Every restart, whether automatic or after the latch, raises `run_aux_o` first. `run_main_o` waits for a fresh `boot_gt_main_i`.
- R10: While reset is asserted, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_on_i | input | 1 | Controller supply above turn-on level |
| ref_ok_i | input | 1 | Internal reference within range |
| in_uv_i | input | 1 | Input voltage below undervoltage threshold |
| in_ov_i | input | 1 | Input voltage above overvoltage threshold |
| ovc_i | input | 1 | Overcurrent fault flag |
| en_i | input | 1 | Enable pin level |
| en_pol_i | input | 1 | Enable polarity select (1: active-low enable) |
| boot_gt_main_i | input | 1 | Bootstrapped supply exceeds main supply |
| boot_low_i | input | 1 | Bootstrapped supply below restart level |
| out_uv_a_i | input | 1 | Auxiliary output undervoltage |
| out_uv_b_i | input | 1 | Main output undervoltage |
| run_aux_o | output | 1 | Release of the auxiliary output |
| run_main_o | output | 1 | Release of the main output pair |
| latched_off_o | output | 1 | Block latched off by the undervoltage timer |

## Verification
The hardest state to reach from the ports is the exit from latched-off. To get there, the bench first drives the block fully running, then holds an output undervoltage flag for exactly the timer length, after proving that a shorter burst split by one clean cycle does not latch. It then toggles enable while each exit condition is missing in turn: the bootstrapped-supply-low flag low, then an output flag still high. Last, it toggles with all conditions met and watches the staged restart follow.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_OFF   = 3'd0,
    SEQ_AUX   = 3'd1,
    SEQ_MAIN  = 3'd2,
    SEQ_HOLD  = 3'd3,
    SEQ_LATCH = 3'd4
  } seq_state_t;
endpackage

// File: rtl/seq_enable_mon.sv
module seq_enable_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic en_pol_i,
  input  logic in_uv_i,
  output logic enabled_o,
  output logic toggle_o
);
  logic en_q;
  logic uv_q;

  // polarity select: high polarity means an active-low enable pin
  assign enabled_o = en_pol_i ? ~en_i : en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      en_q <= en_i;
      uv_q <= in_uv_i;
    end
  end

  assign toggle_o = (en_i ^ en_q) | (in_uv_i ^ uv_q);
endmodule

// File: rtl/seq_uv_timer.sv
module seq_uv_timer #(
  parameter int TMR_LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic running_i,
  input  logic uv_any_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TMR_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMR_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active   = running_i & uv_any_i;
  assign expire_o = active & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (!expire_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import supply_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic boot_gt_main_i,
  input  logic boot_low_i,
  input  logic expire_i,
  input  logic rearm_i,
  output logic run_aux_o,
  output logic run_main_o,
  output logic latched_o
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_OFF:   if (!fault_i) st_d = SEQ_AUX;
      SEQ_AUX: begin
        if (expire_i)            st_d = SEQ_LATCH;
        else if (fault_i)        st_d = SEQ_HOLD;
        else if (boot_gt_main_i) st_d = SEQ_MAIN;
      end
      SEQ_MAIN: begin
        if (expire_i)     st_d = SEQ_LATCH;
        else if (fault_i) st_d = SEQ_HOLD;
      end
      SEQ_HOLD:  if (!fault_i && boot_low_i) st_d = SEQ_AUX;
      SEQ_LATCH: if (rearm_i) st_d = SEQ_OFF;
      default:   st_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SEQ_OFF;
    else        st_q <= st_d;
  end

  assign run_aux_o  = (st_q == SEQ_AUX) | (st_q == SEQ_MAIN);
  assign run_main_o = (st_q == SEQ_MAIN);
  assign latched_o  = (st_q == SEQ_LATCH);
endmodule

// File: rtl/supply_sequencer.sv
module supply_sequencer #(
  parameter int TMR_LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_on_i,
  input  logic ref_ok_i,
  input  logic in_uv_i,
  input  logic in_ov_i,
  input  logic ovc_i,
  input  logic en_i,
  input  logic en_pol_i,
  input  logic boot_gt_main_i,
  input  logic boot_low_i,
  input  logic out_uv_a_i,
  input  logic out_uv_b_i,
  output logic run_aux_o,
  output logic run_main_o,
  output logic latched_off_o
);
  logic enabled;
  logic toggle;
  logic expire;
  logic fault;
  logic uv_any;
  logic rearm;

  seq_enable_mon u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .en_pol_i  (en_pol_i),
    .in_uv_i   (in_uv_i),
    .enabled_o (enabled),
    .toggle_o  (toggle)
  );

  assign uv_any = out_uv_a_i | out_uv_b_i;
  assign fault  = ~supply_on_i | ~ref_ok_i | in_uv_i | in_ov_i | ovc_i | ~enabled;
  assign rearm  = toggle & boot_low_i & ~uv_any;

  seq_uv_timer #(.TMR_LIMIT(TMR_LIMIT)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .running_i (run_aux_o),
    .uv_any_i  (uv_any),
    .expire_o  (expire)
  );

  seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .fault_i        (fault),
    .boot_gt_main_i (boot_gt_main_i),
    .boot_low_i     (boot_low_i),
    .expire_i       (expire),
    .rearm_i        (rearm),
    .run_aux_o      (run_aux_o),
    .run_main_o     (run_main_o),
    .latched_o      (latched_off_o)
  );
endmodule

// File: rtl/supply_sequencer_chk.sv
module supply_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_on_i,
  input logic ref_ok_i,
  input logic in_uv_i,
  input logic in_ov_i,
  input logic ovc_i,
  input logic en_i,
  input logic en_pol_i,
  input logic boot_gt_main_i,
  input logic boot_low_i,
  input logic out_uv_a_i,
  input logic out_uv_b_i,
  input logic run_aux_o,
  input logic run_main_o,
  input logic latched_off_o
);
  logic off_cond;
  assign off_cond = ~supply_on_i | ~ref_ok_i | in_uv_i | in_ov_i | ovc_i |
                    (en_pol_i ? en_i : ~en_i);

  assert_fault_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    off_cond |=> !run_aux_o && !run_main_o);

  assert_aux_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_aux_o) |-> $past(supply_on_i && ref_ok_i));

  assert_main_needs_aux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_main_o |-> run_aux_o);

  assert_main_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_main_o) |-> $past(boot_gt_main_i));

  assert_latch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off_o |-> !run_aux_o && !run_main_o);

  assert_latch_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched_off_o) |-> $past(boot_low_i && !out_uv_a_i && !out_uv_b_i));
endmodule

bind supply_sequencer supply_sequencer_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .supply_on_i    (supply_on_i),
  .ref_ok_i       (ref_ok_i),
  .in_uv_i        (in_uv_i),
  .in_ov_i        (in_ov_i),
  .ovc_i          (ovc_i),
  .en_i           (en_i),
  .en_pol_i       (en_pol_i),
  .boot_gt_main_i (boot_gt_main_i),
  .boot_low_i     (boot_low_i),
  .out_uv_a_i     (out_uv_a_i),
  .out_uv_b_i     (out_uv_b_i),
  .run_aux_o      (run_aux_o),
  .run_main_o     (run_main_o),
  .latched_off_o  (latched_off_o)
);

// File: tb/supply_sequencer_bench.sv
module supply_sequencer_bench;
  localparam int LIM = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_on_i = 1'b0, ref_ok_i = 1'b1, in_uv_i = 1'b0, in_ov_i = 1'b0;
  logic ovc_i = 1'b0, en_i = 1'b0, en_pol_i = 1'b1;
  logic boot_gt_main_i = 1'b0, boot_low_i = 1'b0;
  logic out_uv_a_i = 1'b0, out_uv_b_i = 1'b0;
  logic run_aux_o, run_main_o, latched_off_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  supply_sequencer #(.TMR_LIMIT(LIM)) u_supply_sequencer (
    .clk(clk), .rst_n(rst_n), .supply_on_i(supply_on_i), .ref_ok_i(ref_ok_i),
    .in_uv_i(in_uv_i), .in_ov_i(in_ov_i), .ovc_i(ovc_i), .en_i(en_i),
    .en_pol_i(en_pol_i), .boot_gt_main_i(boot_gt_main_i), .boot_low_i(boot_low_i),
    .out_uv_a_i(out_uv_a_i), .out_uv_b_i(out_uv_b_i), .run_aux_o(run_aux_o),
    .run_main_o(run_main_o), .latched_off_o(latched_off_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect3(input logic a, input logic m, input logic l, input string req);
    checks++;
    if (run_aux_o !== a || run_main_o !== m || latched_off_o !== l) begin
      fails++;
      $display("FAIL %s: aux/main/latch actual %b%b%b expected %b%b%b",
               req, run_aux_o, run_main_o, latched_off_o, a, m, l);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect3(0, 0, 0, "R10 in reset");
    rst_n = 1'b1;
    step(3);
    expect3(0, 0, 0, "R2 no start without supply");
  endtask

  task automatic t_polarity;
    supply_on_i = 1'b1; en_pol_i = 1'b1; en_i = 1'b1;
    step(2);
    expect3(0, 0, 0, "R1 pol high, en high disables");
    en_i = 1'b0;
    step(1);
    expect3(1, 0, 0, "R1 R2 pol high, en low starts aux");
    en_pol_i = 1'b0;
    step(1);
    expect3(0, 0, 0, "R1 R4 pol low, en low disables");
    en_i = 1'b1; boot_low_i = 1'b1;
    step(1);
    expect3(1, 0, 0, "R1 pol low, en high runs");
    boot_low_i = 1'b0; en_pol_i = 1'b1; en_i = 1'b0;
    step(1);
    expect3(1, 0, 0, "R1 polarity swap keeps enabled");
  endtask

  task automatic t_staged;
    step(3);
    expect3(1, 0, 0, "R3 main waits for bootstrap");
    boot_gt_main_i = 1'b1;
    step(1);
    expect3(1, 1, 0, "R3 main released");
  endtask

  task automatic t_faults;
    in_ov_i = 1'b1;
    step(1);
    expect3(0, 0, 0, "R4 overvoltage drops both");
    in_ov_i = 1'b0; boot_gt_main_i = 1'b0;
    step(3);
    expect3(0, 0, 0, "R7 waits for bootstrap low");
    boot_low_i = 1'b1;
    step(1);
    expect3(1, 0, 0, "R7 R9 restart with aux only");
    boot_low_i = 1'b0;
    step(2);
    expect3(1, 0, 0, "R9 main needs fresh bootstrap flag");
    boot_gt_main_i = 1'b1;
    step(1);
    expect3(1, 1, 0, "R9 main after bootstrap");
    ref_ok_i = 1'b0;
    step(1);
    expect3(0, 0, 0, "R4 reference loss drops both");
    ref_ok_i = 1'b1; ovc_i = 1'b1; boot_low_i = 1'b1;
    step(2);
    expect3(0, 0, 0, "R4 R7 overcurrent still present holds off");
    ovc_i = 1'b0;
    step(1);
    expect3(1, 0, 0, "R7 restart after overcurrent clears");
    boot_low_i = 1'b0;
    step(1);
    expect3(1, 1, 0, "R3 main returns");
  endtask

  task automatic t_timer;
    out_uv_a_i = 1'b1;
    step(LIM - 1);
    expect3(1, 1, 0, "R5 no latch before limit");
    out_uv_a_i = 1'b0;
    step(1);
    out_uv_b_i = 1'b1;
    step(LIM - 1);
    expect3(1, 1, 0, "R6 timer cleared by clean cycle");
    step(1);
    expect3(0, 0, 1, "R5 latch at limit");
  endtask

  task automatic t_latched;
    en_i = 1'b1;
    step(1);
    expect3(0, 0, 1, "R8 toggle without bootstrap low ignored");
    en_i = 1'b0;
    step(1);
    expect3(0, 0, 1, "R8 second toggle without bootstrap low ignored");
    boot_low_i = 1'b1; en_i = 1'b1;
    step(1);
    expect3(0, 0, 1, "R8 toggle with output flag high ignored");
    out_uv_b_i = 1'b0;
    step(2);
    expect3(0, 0, 1, "R8 no toggle keeps latch");
    en_i = 1'b0;
    step(1);
    expect3(0, 0, 0, "R8 exit on valid toggle");
    step(1);
    expect3(1, 0, 0, "R9 aux first after latch");
    step(1);
    expect3(1, 1, 0, "R9 then main");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_polarity;
    t_staged;
    t_faults;
    t_timer;
    t_latched;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule